// File: doc/BRIEF.md
# Bit-Serial Configuration Loader

This block loads a programmable device through its bit-serial configuration port. Once a start pulse arrives with a total byte count, it puts the device into its configuration reset. It waits for the device's initialisation flag to rise and then fall again, and then shifts the supplied bytes out one bit per configuration clock. After the last byte it keeps clocking with the data line high until the device reports that it has finished.

Bytes arrive over a valid/ready handshake. A byte is taken only at a byte boundary. If the producer has nothing ready, the configuration clock parks high until a byte arrives.

Every wait for the device is bounded by a timeout counted in system clock cycles. During the load, an initialisation flag that rises while the finished flag is still low is treated as a checksum failure and ends the load at once. The outcome is reported on three sticky flags: success, checksum error and timeout. All three clear at the next accepted start.

Top module: `cfgser_master`

## Requirements
- R1: After reset, cfg_prog_o=0, cfg_clk_o=1, cfg_din_o=1, busy_o=0, in_ready_o=0, and done_ok_o, err_crc_o and err_timeout_o are all 0.
- R2: A start pulse seen while idle sets cfg_prog_o=1 one cycle later and loads byte_count_i. cfg_prog_o stays 1 until cfg_init_i=1 and then drops. No byte is accepted (in_ready_o=0) until cfg_init_i has returned to 0.
- R3: Each of the two initialisation waits ends, if its condition is not met within TIMEOUT_CYCLES cycles, with err_timeout_o=1, busy_o=0 and cfg_prog_o=0. The counter restarts for the second wait.
- R4: Each byte is sent MSB first, 8 bits per byte. cfg_din_o changes only in cycles where cfg_clk_o is 0, so it is stable at every rising edge of cfg_clk_o.
- R5: During data bits, each low phase and each high phase of cfg_clk_o lasts DIV_CYCLES system cycles.
- R6: A byte is taken (in_valid_i && in_ready_o) only at a byte boundary with cfg_clk_o=1. While no byte is valid, in_ready_o stays 1 and cfg_clk_o stays 1.
- R7: Before each byte, if cfg_init_i=1 while cfg_done_i=0, the load stops with err_crc_o=1 and busy_o=0, and no further byte is accepted.
- R8: After the last byte, cfg_din_o is 1 at every rising edge of cfg_clk_o while the clock keeps toggling. When cfg_done_i=1 the load ends with done_ok_o=1 and busy_o=0.
- R9: If cfg_done_i stays 0 for TIMEOUT_CYCLES cycles of trailing clocks, the load ends with err_timeout_o=1 and done_ok_o=0.
- R10: The status flags hold until the next accepted start, which clears them. A start pulse while busy_o=1 has no effect. At most one status flag is 1 at a time.
- R11: A byte count of 0 goes straight from the initialisation handshake to trailing clocks, without raising in_ready_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin a load |
| byte_count_i | input | CNT_W | Number of bytes in the load, sampled with start_i |
| in_valid_i | input | 1 | Byte available on in_data_i |
| in_data_i | input | 8 | Byte to send |
| in_ready_o | output | 1 | Block takes in_data_i this cycle if in_valid_i |
| cfg_prog_o | output | 1 | Configuration reset request to the device, 1 = asserted |
| cfg_clk_o | output | 1 | Configuration clock |
| cfg_din_o | output | 1 | Configuration serial data |
| cfg_init_i | input | 1 | Device initialisation flag, 1 = asserted |
| cfg_done_i | input | 1 | Device finished flag, 1 = finished |
| busy_o | output | 1 | A load is in progress |
| done_ok_o | output | 1 | Sticky: last load finished successfully |
| err_crc_o | output | 1 | Sticky: last load stopped on a checksum error |
| err_timeout_o | output | 1 | Sticky: last load stopped on a timeout |

## Verification
The bench rebuilds every byte from the data line at each rising configuration clock and compares it against a queue of the bytes it fed in. A design that shifted LSB first, dropped a bit, or changed data while the clock was high would show mismatched bytes or short low phases. Each timeout path is provoked: the first initialisation wait, the second one, and the finished wait. The test confirms that the flag does not rise early and does rise just after TIMEOUT_CYCLES, which catches a counter that fails to restart between waits. The checksum abort, a zero-byte load, a stalled producer, and a start pulse during a load are each exercised. A design that kept accepting bytes after the abort, offered a byte with no data owed, let the clock run while stalled, or restarted on a busy start would be caught by the byte count or the output levels.

// File: rtl/cfgser_pkg.sv
package cfgser_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for start
        ST_PROG,   // reset request held, waiting for init flag to rise
        ST_WAKE,   // reset released, waiting for init flag to fall
        ST_FETCH,  // byte boundary: checksum check, take next byte
        ST_LOW,    // data bit, clock low phase
        ST_HIGH,   // data bit, clock high phase
        ST_TLOW,   // trailing clock low phase
        ST_THIGH   // trailing clock high phase
    } cfg_state_e;
endpackage

// File: rtl/cfgser_phase.sv
module cfgser_phase #(
    parameter int DIV_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int PW = (DIV_CYCLES > 1) ? $clog2(DIV_CYCLES) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV_CYCLES - 1);

    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = en_i && (cnt_q == LAST);
        if (!en_i || tick_o) cnt_d = '0;
        else                 cnt_d = cnt_q + PW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/cfgser_timer.sv
module cfgser_timer #(
    parameter int TIMEOUT_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic clr_i,
    output logic expired_o
);
    localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [TW-1:0] LIMIT = TW'(TIMEOUT_CYCLES - 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        expired_o = run_i && (cnt_q == LIMIT);
        if (!run_i || clr_i) cnt_d = '0;
        else if (expired_o)  cnt_d = cnt_q;
        else                 cnt_d = cnt_q + TW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/cfgser_master.sv
module cfgser_master
    import cfgser_pkg::*;
#(
    parameter int CNT_W          = 16,
    parameter int DIV_CYCLES     = 2,
    parameter int TIMEOUT_CYCLES = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] byte_count_i,
    input  logic             in_valid_i,
    input  logic [7:0]       in_data_i,
    output logic             in_ready_o,
    output logic             cfg_prog_o,
    output logic             cfg_clk_o,
    output logic             cfg_din_o,
    input  logic             cfg_init_i,
    input  logic             cfg_done_i,
    output logic             busy_o,
    output logic             done_ok_o,
    output logic             err_crc_o,
    output logic             err_timeout_o
);
    localparam logic [CNT_W-1:0] REM_ONE = CNT_W'(1);

    typedef struct packed {
        cfg_state_e       st;
        logic [CNT_W-1:0] rem;
        logic [7:0]       sh;
        logic [2:0]       bitn;
        logic             prog;
        logic             cclk;
        logic             din;
        logic             ok;
        logic             crc;
        logic             tmo;
    } regs_t;

    regs_t d, q;
    logic  ph_en, ph_tick, tmr_run, tmr_clr, tmr_exp, ready;

    cfgser_phase #(.DIV_CYCLES(DIV_CYCLES)) u_phase (
        .clk(clk), .rst_n(rst_n), .en_i(ph_en), .tick_o(ph_tick)
    );

    cfgser_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .run_i(tmr_run), .clr_i(tmr_clr),
        .expired_o(tmr_exp)
    );

    always_comb begin
        d       = q;
        ph_en   = 1'b0;
        tmr_run = 1'b0;
        tmr_clr = 1'b0;
        ready   = 1'b0;
        unique case (q.st)
            ST_IDLE: if (start_i) begin
                d.st   = ST_PROG;
                d.prog = 1'b1;
                d.rem  = byte_count_i;
                d.ok   = 1'b0;
                d.crc  = 1'b0;
                d.tmo  = 1'b0;
            end
            ST_PROG: begin
                tmr_run = 1'b1;
                if (cfg_init_i) begin
                    d.st    = ST_WAKE;
                    d.prog  = 1'b0;
                    tmr_clr = 1'b1;
                end else if (tmr_exp) begin
                    d.st   = ST_IDLE;
                    d.prog = 1'b0;
                    d.tmo  = 1'b1;
                end
            end
            ST_WAKE: begin
                tmr_run = 1'b1;
                if (!cfg_init_i) d.st = ST_FETCH;
                else if (tmr_exp) begin
                    d.st  = ST_IDLE;
                    d.tmo = 1'b1;
                end
            end
            ST_FETCH: begin
                if (cfg_init_i && !cfg_done_i) begin
                    d.st  = ST_IDLE;
                    d.crc = 1'b1;
                end else if (q.rem == '0) begin
                    d.st   = ST_TLOW;
                    d.cclk = 1'b0;
                    d.din  = 1'b1;
                end else begin
                    ready = 1'b1;
                    if (in_valid_i) begin
                        d.st   = ST_LOW;
                        d.cclk = 1'b0;
                        d.din  = in_data_i[7];
                        d.sh   = {in_data_i[6:0], 1'b0};
                        d.bitn = '0;
                        d.rem  = q.rem - REM_ONE;
                    end
                end
            end
            ST_LOW: begin
                ph_en = 1'b1;
                if (ph_tick) begin
                    d.st   = ST_HIGH;
                    d.cclk = 1'b1;
                end
            end
            ST_HIGH: begin
                ph_en = 1'b1;
                if (ph_tick) begin
                    if (q.bitn == 3'd7) d.st = ST_FETCH;
                    else begin
                        d.st   = ST_LOW;
                        d.cclk = 1'b0;
                        d.din  = q.sh[7];
                        d.sh   = {q.sh[6:0], 1'b0};
                        d.bitn = q.bitn + 3'd1;
                    end
                end
            end
            ST_TLOW, ST_THIGH: begin
                ph_en   = 1'b1;
                tmr_run = 1'b1;
                if (cfg_done_i) begin
                    d.st   = ST_IDLE;
                    d.cclk = 1'b1;
                    d.ok   = 1'b1;
                end else if (tmr_exp) begin
                    d.st   = ST_IDLE;
                    d.cclk = 1'b1;
                    d.tmo  = 1'b1;
                end else if (ph_tick) begin
                    d.st   = (q.st == ST_TLOW) ? ST_THIGH : ST_TLOW;
                    d.cclk = (q.st == ST_TLOW);
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '{st: ST_IDLE, rem: '0, sh: '0, bitn: '0, prog: 1'b0,
                   cclk: 1'b1, din: 1'b1, ok: 1'b0, crc: 1'b0, tmo: 1'b0};
        else
            q <= d;
    end

    assign in_ready_o    = ready;
    assign cfg_prog_o    = q.prog;
    assign cfg_clk_o     = q.cclk;
    assign cfg_din_o     = q.din;
    assign busy_o        = (q.st != ST_IDLE);
    assign done_ok_o     = q.ok;
    assign err_crc_o     = q.crc;
    assign err_timeout_o = q.tmo;

    // Data line never moves while the configuration clock is high.
    assert_din_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_clk_o |-> $stable(cfg_din_o));

    // A low phase of a running load spans more than one cycle.
    if (DIV_CYCLES > 1) begin : g_low_len
        assert_low_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(cfg_clk_o) |=> (!cfg_clk_o || !busy_o));
    end

    // Bytes are offered only at a byte boundary with the clock parked high.
    assert_ready_clk_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready_o |-> (cfg_clk_o && !cfg_prog_o));

    // Clock stays parked high during the reset request.
    assert_prog_clk_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_prog_o |-> cfg_clk_o);

    // Outcome flags are exclusive and cleared while a load runs.
    assert_one_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({done_ok_o, err_crc_o, err_timeout_o}) <= 1);
    assert_busy_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !(done_ok_o || err_crc_o || err_timeout_o));

    // A checksum abort happens only with the init flag up and done low.
    assert_crc_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_crc_o) |-> $past(cfg_init_i && !cfg_done_i));
endmodule

// File: tb/cfgser_master_tb.sv
module cfgser_master_tb;
    localparam int CNT_W = 16;
    localparam int DIV   = 2;
    localparam int TMO   = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [CNT_W-1:0] byte_count_i = '0;
    logic in_valid_i = 1'b0;
    logic [7:0] in_data_i = '0;
    logic cfg_init_i = 1'b0;
    logic cfg_done_i = 1'b0;
    logic in_ready_o, cfg_prog_o, cfg_clk_o, cfg_din_o;
    logic busy_o, done_ok_o, err_crc_o, err_timeout_o;

    always #10 clk = ~clk;

    cfgser_master #(.CNT_W(CNT_W), .DIV_CYCLES(DIV), .TIMEOUT_CYCLES(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_count_i(byte_count_i),
        .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_ready_o(in_ready_o),
        .cfg_prog_o(cfg_prog_o), .cfg_clk_o(cfg_clk_o), .cfg_din_o(cfg_din_o),
        .cfg_init_i(cfg_init_i), .cfg_done_i(cfg_done_i), .busy_o(busy_o),
        .done_ok_o(done_ok_o), .err_crc_o(err_crc_o), .err_timeout_o(err_timeout_o)
    );

    int checks = 0;
    int errors = 0;
    bit reported = 1'b0;
    logic [7:0] exp_q[$];
    int rx_count = 0;
    int trail_rises = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!reported) begin
            reported = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Monitor: rebuild bytes from the serial line and compare against the queue.
    logic prev_clk = 1'b1;
    int   low_cnt = 0;
    int   nbits = 0;
    logic [7:0] acc = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!cfg_clk_o) low_cnt++;
            else if (!prev_clk) begin
                if (exp_q.size() > 0) begin
                    logic [7:0] e;
                    check(low_cnt == DIV, "R5 low phase length", low_cnt, DIV);
                    acc = {acc[6:0], cfg_din_o};
                    nbits++;
                    if (nbits == 8) begin
                        e = exp_q.pop_front();
                        check(acc == e, "R4 byte MSB first", acc, e);
                        rx_count++;
                        nbits = 0;
                    end
                end else begin
                    trail_rises++;
                    check(cfg_din_o == 1'b1, "R8 trailing din high", cfg_din_o, 1);
                end
                low_cnt = 0;
            end
            prev_clk = cfg_clk_o;
        end
    end

    task automatic pulse_start(input int cnt);
        @(negedge clk);
        start_i = 1'b1;
        byte_count_i = CNT_W'(cnt);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic handshake();
        repeat (4) @(negedge clk);
        cfg_init_i = 1'b1;
        repeat (3) @(negedge clk);
        cfg_init_i = 1'b0;
    endtask

    // Driver: queue the expected byte, then hand it over on valid/ready.
    task automatic send_byte(input logic [7:0] b);
        exp_q.push_back(b);
        @(negedge clk);
        in_valid_i = 1'b1;
        in_data_i  = b;
        while (!in_ready_o) @(negedge clk);
        @(negedge clk);
        in_valid_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cfg_prog_o == 0, "R1 prog", cfg_prog_o, 0);
        check(cfg_clk_o == 1, "R1 clk", cfg_clk_o, 1);
        check(cfg_din_o == 1, "R1 din", cfg_din_o, 1);
        check(busy_o == 0 && in_ready_o == 0, "R1 busy/ready", busy_o, 0);
        check({done_ok_o, err_crc_o, err_timeout_o} == 0, "R1 status",
              {done_ok_o, err_crc_o, err_timeout_o}, 0);

        // Normal load of three bytes
        pulse_start(3);
        check(cfg_prog_o == 1, "R2 prog asserted", cfg_prog_o, 1);
        repeat (3) @(negedge clk);
        check(cfg_prog_o == 1, "R2 prog held until init", cfg_prog_o, 1);
        cfg_init_i = 1'b1;
        repeat (2) @(negedge clk);
        check(cfg_prog_o == 0, "R2 prog released", cfg_prog_o, 0);
        check(in_ready_o == 0, "R2 no data while init high", in_ready_o, 1'b0);
        repeat (3) @(negedge clk);
        cfg_init_i = 1'b0;
        send_byte(8'hA5);
        // stall: producer idle at a byte boundary
        while (!in_ready_o) @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            check(in_ready_o == 1 && cfg_clk_o == 1, "R6 stall clock high",
                  {in_ready_o, cfg_clk_o}, 3);
            @(negedge clk);
        end
        // start while busy
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (2) @(negedge clk);
        check(cfg_prog_o == 0 && busy_o == 1, "R10 start while busy ignored",
              {cfg_prog_o, busy_o}, 1);
        send_byte(8'h01);
        send_byte(8'h80);
        while (exp_q.size() != 0) @(negedge clk);
        check(rx_count == 3, "R4 bytes received", rx_count, 3);
        base = trail_rises;
        repeat (20) @(negedge clk);
        check(trail_rises > base && busy_o == 1, "R8 trailing clocks", trail_rises - base, 1);
        cfg_done_i = 1'b1;
        repeat (3) @(negedge clk);
        check(done_ok_o == 1 && busy_o == 0, "R8 success", {done_ok_o, busy_o}, 2);
        cfg_done_i = 1'b0;
        repeat (10) @(negedge clk);
        check(done_ok_o == 1, "R10 success sticky", done_ok_o, 1);

        // Checksum error between bytes
        pulse_start(3);
        repeat (2) @(negedge clk);
        check(done_ok_o == 0, "R10 cleared at start", done_ok_o, 0);
        handshake();
        base = rx_count;
        send_byte(8'h3C);
        cfg_init_i = 1'b1;
        @(negedge clk);
        in_valid_i = 1'b1;
        in_data_i  = 8'h77;
        repeat (40) @(negedge clk);
        check(err_crc_o == 1 && busy_o == 0, "R7 crc abort", {err_crc_o, busy_o}, 2);
        check(rx_count - base == 1 && in_ready_o == 0, "R7 no byte after abort",
              rx_count - base, 1);
        check(err_timeout_o == 0, "R7 no timeout flag", err_timeout_o, 0);
        in_valid_i = 1'b0;
        cfg_init_i = 1'b0;

        // Timeout in first init wait
        pulse_start(1);
        check(err_crc_o == 0, "R10 crc cleared at start", err_crc_o, 0);
        repeat (TMO - 4) @(negedge clk);
        check(err_timeout_o == 0 && busy_o == 1, "R3 not early (wait 1)", err_timeout_o, 0);
        repeat (6) @(negedge clk);
        check(err_timeout_o == 1 && busy_o == 0 && cfg_prog_o == 0, "R3 timeout wait 1",
              {err_timeout_o, busy_o, cfg_prog_o}, 4);

        // Timeout in second init wait (counter restarts)
        pulse_start(1);
        repeat (TMO - 10) @(negedge clk);
        cfg_init_i = 1'b1;
        repeat (TMO - 4) @(negedge clk);
        check(err_timeout_o == 0 && busy_o == 1, "R3 timer restarted", err_timeout_o, 0);
        repeat (8) @(negedge clk);
        check(err_timeout_o == 1 && busy_o == 0, "R3 timeout wait 2",
              {err_timeout_o, busy_o}, 2);
        cfg_init_i = 1'b0;

        // Zero byte load, then done timeout
        pulse_start(0);
        handshake();
        base = trail_rises;
        for (int i = 0; i < 20; i++) begin
            check(in_ready_o == 0, "R11 no byte offered", in_ready_o, 0);
            @(negedge clk);
        end
        check(trail_rises > base, "R11 trailing clocks at once", trail_rises - base, 1);
        repeat (TMO + 10) @(negedge clk);
        check(err_timeout_o == 1 && done_ok_o == 0 && busy_o == 0, "R9 done timeout",
              {err_timeout_o, done_ok_o, busy_o}, 4);

        finish_run();
    end
endmodule